// File: doc/BRIEF.md
# Serial port register file with prioritized interrupts

This block is the processor-side half of a single-channel asynchronous serial port without receive or transmit queues. A host reaches ten registers through a 3-bit address on a one-cycle read/write strobe bus. Bit 7 of the line settings register overlays addresses 0 and 1 with the two bytes of the baud divisor. The block holds one received byte and one byte waiting for transmission, collects receive errors and modem-line changes, and raises one active-high interrupt whose cause can be read back as a priority code.

The serializer side uses two streams. Outgoing bytes leave on `tx_valid`/`tx_ready`: `tx_valid` stays high and `tx_data` stays fixed until the serializer takes the byte with `tx_ready`. The transmit path has no deeper storage, so back-pressure is resolved by holding that single byte. Incoming bytes arrive on `rx_valid` without a ready signal because the receive holding byte is always overwritten. A byte that arrives while the previous one is still unread is recorded as an overrun.

Read data is combinational from the current address. The side effects of a read (flag clears) take place at the clock edge that ends the strobe cycle.

Top module: `uart_regfile`

## Requirements
- R1: After `rst`, reads return 0x00 at address 1 (enable), 0x01 at address 2 (identity), 0x00 at address 3 (line settings), 0x00 at address 4 (modem control) and 0x60 at address 5 (line status). Address 6 shows zero change bits. `irq` and `tx_valid` are low.
- R2: While line settings bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 reads and writes the divisor high byte. These accesses do not touch the transmit byte or the enable register. Scratch and divisor values survive `rst`.
- R3: While line settings bit 7 is 0, a write to address 0 loads the transmit byte and a read of address 0 returns the received byte. Address 1 is the enable register, and its bits 7..4 read as zero.
- R4: Address 7 is a plain scratch byte. Address 4 keeps bits 4..0, drives them on `modem_ctl`, and reads bits 7..5 as zero.
- R5: A transmit byte holds `tx_valid` high with stable `tx_data` until `tx_ready`. Line status bit 5 (holding empty) is low while a byte waits. Line status bit 6 is high only when the holding byte is empty and `tx_idle` is high.
- R6: `rx_valid` stores `rx_data` and sets line status bit 0. Reading the received byte clears bit 0 unless a new byte arrives in the same cycle. A byte arriving while bit 0 is set and no read is in progress sets bit 1 (overrun). `rx_err` bits 0, 1 and 2 set line status bits 2 (parity), 3 (framing) and 4 (break).
- R7: Reading line status clears bits 4..1. A new error in the same cycle wins over the clear.
- R8: Modem status bits 4, 5, 6 and 7 follow `cts`, `dsr`, `ri` and `dcd`. Bits 0, 1 and 3 latch any change of `cts`, `dsr` and `dcd`. Bit 2 latches a falling `ri`. Reading address 6 clears bits 3..0.
- R9: The identity register reads {5'b0, code}. The code is 3'b110 for a line error (status bits 4..1), 3'b100 for received data, 3'b010 for transmit holding empty, 3'b000 for a modem change, and 3'b001 when nothing is pending. The higher entry in that list wins.
- R10: The transmit-empty cause is raised when the serializer takes a byte, or when enable bit 1 is written from 0 to 1 while the holding byte is empty. It clears on a transmit-byte write, or on an identity read that reports code 3'b010.
- R11: Enable bits 0, 1, 2 and 3 gate received data, transmit empty, line error and modem change. A masked cause shows neither in `irq` nor in the identity code. `irq` is high exactly when some enabled cause pends.
- R12: Writes to addresses 2, 5 and 6 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| wr_en | input | 1 | One-cycle register write strobe |
| rd_en | input | 1 | One-cycle register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_ready | input | 1 | Serializer takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| tx_idle | input | 1 | Serializer has nothing in its shifter |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_err | input | 3 | Received byte errors: 0 parity, 1 framing, 2 break |
| cts | input | 1 | Clear-to-send level, active high |
| dsr | input | 1 | Data-set-ready level, active high |
| ri | input | 1 | Ring level, active high |
| dcd | input | 1 | Carrier level, active high |
| line_ctl | output | 8 | Line settings register |
| divisor | output | 16 | Baud divisor {high, low} |
| modem_ctl | output | 5 | Modem control bits 4..0 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The embedded properties check these rules on every cycle:
- the transmit byte stays stable under back-pressure;
- the data-ready flag sets after every received byte;
- error flags and change bits clear after their status read when no new event coincides;
- the divisor holds across cycles without a divisor write;
- a fully masked enable register keeps `irq` low;
- an enabled line error always wins the identity code.

Only the bench scenarios can show the full address overlay, the exact reset values, and the survival of scratch and divisor contents across a second reset. The same holds for the priority ladder as each cause is cleared by its own access, the enable-rising source of the transmit-empty cause, and the ignored writes to read-only addresses.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

  typedef enum logic [2:0] {
    RA_DATA = 3'd0,
    RA_IEN  = 3'd1,
    RA_IDN  = 3'd2,
    RA_LSET = 3'd3,
    RA_MCTL = 3'd4,
    RA_LSTS = 3'd5,
    RA_MSTS = 3'd6,
    RA_SCR  = 3'd7
  } reg_addr_e;

  localparam logic [2:0] ID_LINE = 3'b110;
  localparam logic [2:0] ID_RXD  = 3'b100;
  localparam logic [2:0] ID_TXE  = 3'b010;
  localparam logic [2:0] ID_MDM  = 3'b000;
  localparam logic [2:0] ID_NONE = 3'b001;

  typedef struct packed {
    logic thr_wr;
    logic rbr_rd;
    logic dvl_wr;
    logic dvh_wr;
    logic ien_wr;
    logic idn_rd;
    logic lset_wr;
    logic mctl_wr;
    logic lsts_rd;
    logic msts_rd;
    logic scr_wr;
  } acc_s;

endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic       dlab,
  output acc_s       acc
);
  always_comb begin
    acc = '0;
    case (reg_addr_e'(addr))
      RA_DATA: begin
        acc.thr_wr = wr_en & ~dlab;
        acc.rbr_rd = rd_en & ~dlab;
        acc.dvl_wr = wr_en & dlab;
      end
      RA_IEN: begin
        acc.ien_wr = wr_en & ~dlab;
        acc.dvh_wr = wr_en & dlab;
      end
      RA_IDN:  acc.idn_rd  = rd_en;
      RA_LSET: acc.lset_wr = wr_en;
      RA_MCTL: acc.mctl_wr = wr_en;
      RA_LSTS: acc.lsts_rd = rd_en;
      RA_MSTS: acc.msts_rd = rd_en;
      RA_SCR:  acc.scr_wr  = wr_en;
      default: acc = '0;
    endcase
  end
endmodule

// File: rtl/uart_rf_line.sv
module uart_rf_line #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thr_wr,
  input  logic              rbr_rd,
  input  logic              lsts_rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [2:0]        rx_err,
  input  logic              tx_ready,
  input  logic              tx_idle,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_done,
  output logic [DATA_W-1:0] rbr,
  output logic [7:0]        lsts
);
  logic              thr_empty, temt, dr, oe, pe, fe, bi;
  logic              thr_empty_nx;
  logic [DATA_W-1:0] thr;

  assign tx_valid = ~thr_empty;
  assign tx_data  = thr;
  assign tx_done  = tx_valid & tx_ready;

  always_comb begin
    thr_empty_nx = thr_empty;
    if (thr_wr)       thr_empty_nx = 1'b0;
    else if (tx_done) thr_empty_nx = 1'b1;
  end

  // data bytes keep their contents across reset
  always_ff @(posedge clk) begin
    if (thr_wr)   thr <= wdata;
    if (rx_valid) rbr <= rx_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_empty <= 1'b1;
      temt      <= 1'b1;
      dr        <= 1'b0;
      oe        <= 1'b0;
      pe        <= 1'b0;
      fe        <= 1'b0;
      bi        <= 1'b0;
    end else begin
      thr_empty <= thr_empty_nx;
      temt      <= thr_empty_nx & tx_idle;
      if (rx_valid)    dr <= 1'b1;
      else if (rbr_rd) dr <= 1'b0;
      oe <= (oe & ~lsts_rd) | (rx_valid & dr & ~rbr_rd);
      pe <= (pe & ~lsts_rd) | (rx_valid & rx_err[0]);
      fe <= (fe & ~lsts_rd) | (rx_valid & rx_err[1]);
      bi <= (bi & ~lsts_rd) | (rx_valid & rx_err[2]);
    end
  end

  assign lsts = {1'b0, temt, thr_empty, bi, fe, pe, oe, dr};

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !thr_wr) |=> (tx_valid && $stable(tx_data)));

  assert_dr_set_R6: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> lsts[0]);

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (lsts_rd && !rx_valid) |=> (lsts[4:1] == 4'b0));
endmodule

// File: rtl/uart_rf_modem.sv
module uart_rf_modem (
  input  logic       clk,
  input  logic       rst,
  input  logic       msts_rd,
  input  logic       cts,
  input  logic       dsr,
  input  logic       ri,
  input  logic       dcd,
  output logic [7:0] msts
);
  logic [3:0] lvl, prev, dlt, chg;

  assign lvl = {dcd, ri, dsr, cts};
  assign chg = {lvl[3] ^ prev[3], ~lvl[2] & prev[2], lvl[1] ^ prev[1], lvl[0] ^ prev[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= lvl;
      dlt  <= '0;
    end else begin
      prev <= lvl;
      dlt  <= (dlt & ~{4{msts_rd}}) | chg;
    end
  end

  assign msts = {lvl, dlt};

  assert_delta_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (msts_rd && $stable(cts) && $stable(dsr) && $stable(ri) && $stable(dcd))
      |=> (msts[3:0] == 4'b0));
endmodule

// File: rtl/uart_rf_intc.sv
module uart_rf_intc
  import uart_rf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ien_wr,
  input  logic [3:0] ien_wdata,
  input  logic       idn_rd,
  input  logic       thr_wr,
  input  logic       tx_done,
  input  logic       thr_empty,
  input  logic       line_err,
  input  logic       data_rdy,
  input  logic       mdm_chg,
  output logic [3:0] ien,
  output logic [2:0] id_code,
  output logic       irq
);
  logic txe_pend, txe_set;

  assign txe_set = tx_done | (ien_wr & ien_wdata[1] & ~ien[1] & thr_empty);

  always_ff @(posedge clk) begin
    if (rst) begin
      ien      <= '0;
      txe_pend <= 1'b0;
    end else begin
      if (ien_wr) ien <= ien_wdata;
      if (thr_wr)                            txe_pend <= 1'b0;
      else if (txe_set)                      txe_pend <= 1'b1;
      else if (idn_rd && id_code == ID_TXE)  txe_pend <= 1'b0;
    end
  end

  always_comb begin
    if (ien[2] && line_err)      id_code = ID_LINE;
    else if (ien[0] && data_rdy) id_code = ID_RXD;
    else if (ien[1] && txe_pend) id_code = ID_TXE;
    else if (ien[3] && mdm_chg)  id_code = ID_MDM;
    else                         id_code = ID_NONE;
  end

  assign irq = ~id_code[0];

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (ien == 4'b0) |-> !irq);

  assert_line_first_R9: assert property (@(posedge clk) disable iff (rst)
    (ien[2] && line_err) |-> (id_code == ID_LINE));
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_idle,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [2:0]        rx_err,
  input  logic              cts,
  input  logic              dsr,
  input  logic              ri,
  input  logic              dcd,
  output logic [DATA_W-1:0] line_ctl,
  output logic [DIV_W-1:0]  divisor,
  output logic [4:0]        modem_ctl,
  output logic              irq
);
  acc_s              acc;
  logic [DATA_W-1:0] lset, scr, dvl, dvh, rbr;
  logic [4:0]        mctl;
  logic [7:0]        lsts, msts;
  logic [3:0]        ien;
  logic [2:0]        id_code;
  logic              tx_done;

  uart_rf_decode u_dec (
    .wr_en (wr_en), .rd_en (rd_en), .addr (addr), .dlab (lset[7]), .acc (acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lset <= '0;
      mctl <= '0;
    end else begin
      if (acc.lset_wr) lset <= wdata;
      if (acc.mctl_wr) mctl <= wdata[4:0];
    end
  end

  // scratch and divisor are left untouched by reset
  always_ff @(posedge clk) begin
    if (acc.scr_wr) scr <= wdata;
    if (acc.dvl_wr) dvl <= wdata;
    if (acc.dvh_wr) dvh <= wdata;
  end

  uart_rf_line #(.DATA_W(DATA_W)) u_line (
    .clk (clk), .rst (rst),
    .thr_wr (acc.thr_wr), .rbr_rd (acc.rbr_rd), .lsts_rd (acc.lsts_rd),
    .wdata (wdata),
    .rx_valid (rx_valid), .rx_data (rx_data), .rx_err (rx_err),
    .tx_ready (tx_ready), .tx_idle (tx_idle),
    .tx_valid (tx_valid), .tx_data (tx_data), .tx_done (tx_done),
    .rbr (rbr), .lsts (lsts)
  );

  uart_rf_modem u_mdm (
    .clk (clk), .rst (rst), .msts_rd (acc.msts_rd),
    .cts (cts), .dsr (dsr), .ri (ri), .dcd (dcd), .msts (msts)
  );

  uart_rf_intc u_intc (
    .clk (clk), .rst (rst),
    .ien_wr (acc.ien_wr), .ien_wdata (wdata[3:0]), .idn_rd (acc.idn_rd),
    .thr_wr (acc.thr_wr), .tx_done (tx_done), .thr_empty (lsts[5]),
    .line_err (|lsts[4:1]), .data_rdy (lsts[0]), .mdm_chg (|msts[3:0]),
    .ien (ien), .id_code (id_code), .irq (irq)
  );

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      RA_DATA: rdata = lset[7] ? dvl : rbr;
      RA_IEN:  rdata = lset[7] ? dvh : {{(DATA_W-4){1'b0}}, ien};
      RA_IDN:  rdata = {{(DATA_W-3){1'b0}}, id_code};
      RA_LSET: rdata = lset;
      RA_MCTL: rdata = {{(DATA_W-5){1'b0}}, mctl};
      RA_LSTS: rdata = DATA_W'(lsts);
      RA_MSTS: rdata = DATA_W'(msts);
      RA_SCR:  rdata = scr;
      default: rdata = '0;
    endcase
  end

  assign line_ctl  = lset;
  assign divisor   = {dvh, dvl};
  assign modem_ctl = mctl;

  assert_div_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && lset[7] && (addr == 3'd0 || addr == 3'd1)) |=> $stable(divisor));
endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic       tx_valid, tx_ready = 0, tx_idle = 1;
  logic [7:0] tx_data;
  logic       rx_valid = 0;
  logic [7:0] rx_data = 0;
  logic [2:0] rx_err = 0;
  logic       cts = 0, dsr = 0, ri = 0, dcd = 0;
  logic [7:0] line_ctl;
  logic [15:0] divisor;
  logic [4:0] modem_ctl;
  logic       irq;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  uart_regfile dut (
    .clk (clk), .rst (rst), .wr_en (wr_en), .rd_en (rd_en), .addr (addr),
    .wdata (wdata), .rdata (rdata), .tx_valid (tx_valid), .tx_ready (tx_ready),
    .tx_data (tx_data), .tx_idle (tx_idle), .rx_valid (rx_valid),
    .rx_data (rx_data), .rx_err (rx_err), .cts (cts), .dsr (dsr), .ri (ri),
    .dcd (dcd), .line_ctl (line_ctl), .divisor (divisor),
    .modem_ctl (modem_ctl), .irq (irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data one ns after the strobe is driven
  always @(negedge clk) begin
    #1;
    if (rd_en) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
      else check(tag_q.pop_front(), {24'b0, rdata}, {24'b0, exp_q.pop_front()});
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string tag);
    @(negedge clk); addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rx(logic [7:0] d, logic [2:0] e);
    @(negedge clk); rx_data = d; rx_err = e; rx_valid = 1;
    @(negedge clk); rx_valid = 0; rx_err = 0;
  endtask

  task automatic take;
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic settle;
    @(negedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    settle;
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);
    rd(1, 8'h00, "R1 enable");
    rd(2, 8'h01, "R1 identity");
    rd(3, 8'h00, "R1 line settings");
    rd(4, 8'h00, "R1 modem control");
    rd(5, 8'h60, "R1 line status");
    rd(6, 8'h00, "R1 modem status");

    // scratch and modem control
    wr(7, 8'hA5); rd(7, 8'hA5, "R4 scratch");
    wr(4, 8'hFF); rd(4, 8'h1F, "R4 modem control mask");
    settle; check("R4 modem_ctl", modem_ctl, 5'h1F);
    wr(4, 8'h00);

    // divisor overlay
    wr(3, 8'h83); wr(0, 8'h34); wr(1, 8'h12);
    settle;
    check("R2 divisor out", divisor, 16'h1234);
    check("R2 no tx byte", tx_valid, 0);
    rd(0, 8'h34, "R2 divisor low");
    rd(1, 8'h12, "R2 divisor high");
    rd(3, 8'h83, "R2 line settings");
    wr(3, 8'h03);
    settle; check("R2 line_ctl", line_ctl, 8'h03);
    rd(1, 8'h00, "R2 enable untouched");

    // enable register, transmit-empty raised by enabling
    wr(1, 8'hFF);
    rd(1, 8'h0F, "R3 enable upper zero");
    settle; check("R10 irq on enable", irq, 1);
    rd(2, 8'h02, "R10 txe by enable");
    rd(2, 8'h01, "R10 cleared by identity read");

    // transmit stream
    tx_idle = 0;
    wr(0, 8'h5A);
    settle;
    check("R3 tx_valid", tx_valid, 1);
    check("R3 tx_data", tx_data, 8'h5A);
    rd(5, 8'h00, "R5 status while waiting");
    repeat (3) settle;
    check("R5 held valid", tx_valid, 1);
    check("R5 held data", tx_data, 8'h5A);
    take;
    settle; check("R5 taken", tx_valid, 0);
    rd(5, 8'h20, "R5 empty not idle");
    tx_idle = 1;
    settle;
    rd(5, 8'h60, "R5 empty and idle");
    rd(2, 8'h02, "R10 txe after take");
    wr(0, 8'h77);
    rd(2, 8'h01, "R10 cleared by write");
    take;
    rd(2, 8'h02, "R10 txe again");
    rd(2, 8'h01, "R10 identity clear");

    // receive path
    rx(8'hC3, 3'b000);
    rd(2, 8'h04, "R9 data available");
    rd(5, 8'h61, "R6 data ready");
    rd(0, 8'hC3, "R3 received byte");
    rd(5, 8'h60, "R6 ready cleared");
    rd(2, 8'h01, "R9 none");
    rx(8'h11, 3'b000); rx(8'h22, 3'b000);
    rd(2, 8'h06, "R9 overrun is line error");
    rd(5, 8'h63, "R6 overrun");
    rd(2, 8'h04, "R7 line cleared, data left");
    rd(0, 8'h22, "R6 newest byte kept");
    rx(8'h00, 3'b011);
    rd(2, 8'h06, "R9 line error");
    rd(5, 8'h6D, "R6 parity and framing");
    rd(5, 8'h61, "R7 errors cleared");
    rd(0, 8'h00, "R6 byte read");
    rx(8'h00, 3'b100);
    rd(5, 8'h71, "R6 break");
    rd(0, 8'h00, "R6 byte read 2");
    rd(5, 8'h60, "R7 break cleared");

    // masking
    wr(1, 8'h00);
    rx(8'h44, 3'b001);
    settle; check("R11 masked irq", irq, 0);
    rd(2, 8'h01, "R11 masked identity");
    rd(5, 8'h65, "R11 status still set");
    wr(1, 8'h0F);
    rd(2, 8'h04, "R9 data over txe");
    rd(0, 8'h44, "R3 masked byte");
    rd(2, 8'h02, "R9 txe next");
    rd(2, 8'h01, "R10 cleared");

    // modem status
    cts = 1;
    settle; settle;
    check("R11 modem irq", irq, 1);
    rd(2, 8'h00, "R9 modem code");
    rd(6, 8'h11, "R8 cts change");
    rd(6, 8'h10, "R8 cleared");
    rd(2, 8'h01, "R8 identity none");
    ri = 1; settle;
    rd(6, 8'h50, "R8 ri rise no delta");
    ri = 0; settle;
    rd(6, 8'h14, "R8 ri fall delta");
    dsr = 1; dcd = 1; settle;
    rd(6, 8'hBA, "R8 dsr dcd change");
    rd(6, 8'hB0, "R8 cleared 2");

    // full priority ladder
    cts = 0; settle;
    rx(8'h99, 3'b001);
    wr(1, 8'h0D); wr(1, 8'h0F);
    rd(2, 8'h06, "R9 ladder line");
    rd(5, 8'h65, "R9 ladder status");
    rd(2, 8'h04, "R9 ladder data");
    rd(0, 8'h99, "R9 ladder byte");
    rd(2, 8'h02, "R9 ladder txe");
    rd(2, 8'h00, "R9 ladder modem");
    rd(6, 8'hA1, "R9 ladder modem status");
    rd(2, 8'h01, "R9 ladder none");
    settle; check("R11 irq low", irq, 0);

    // read-only addresses
    wr(5, 8'hFF); rd(5, 8'h60, "R12 line status write");
    wr(6, 8'hFF); rd(6, 8'hA0, "R12 modem status write");
    wr(2, 8'hFF); rd(2, 8'h01, "R12 identity write");

    // second reset
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    rd(7, 8'hA5, "R2 scratch survives");
    rd(3, 8'h00, "R1 line settings again");
    rd(1, 8'h00, "R1 enable again");
    rd(5, 8'h60, "R1 status again");
    settle; check("R2 divisor survives", divisor, 16'h1234);
    wr(3, 8'h80);
    rd(0, 8'h34, "R2 low after reset");
    rd(1, 8'h12, "R2 high after reset");

    repeat (3) settle;
    check("scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule